// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one I2C master transfer from a handful of register-style inputs. Software presents a 7-bit target address, a byte count and a direction. It then pulses a command write that carries a start request and an optional stop request. The sequencer orders the bus operations: START (or repeated START), the address byte, the counted data bytes, and finally STOP, unless the stop was left out. Individual operations go to a separate bit-timing engine over a request/done handshake. Transmit bytes are popped from a TX FIFO and received bytes are pushed into an RX FIFO. The bus itself, the SCL timing and the FIFO storage all sit outside this block.

When no stop is requested, the sequencer keeps the bus after the transfer. The next start is then sent as a repeated START, even though the bus-busy flag is still set. A separate bus-busy tracker follows START and STOP conditions seen on the bus, so a fresh transfer waits for a free bus. Three sticky flags report the outcome: transfer finished, no acknowledge, and arbitration lost. Losing arbitration also withdraws master mode until software takes it down and back up.

The state machine has these states:
- IDLE waits for a command.
- WAIT_BUS waits for the bus to go free.
- START issues the start condition.
- ADDR sends the address byte.
- TX_FETCH pops a byte and TX_BYTE sends it.
- RX_ROOM waits for FIFO space and RX_BYTE reads a byte.
- STOP issues the stop condition.

The transitions are:
- IDLE to START on an accepted start when the bus is held or free.
- IDLE to WAIT_BUS on an accepted start when the bus is busy and not held.
- IDLE to STOP on a stop-only write while the bus is held.
- WAIT_BUS to START when the bus frees.
- START to ADDR.
- ADDR to TX_FETCH or RX_ROOM, depending on direction.
- TX_FETCH to TX_BYTE, and TX_BYTE back to TX_FETCH while bytes remain.
- RX_ROOM to RX_BYTE, and RX_BYTE back to RX_ROOM while bytes remain.
- An end of data, or a NACK in ADDR or TX_BYTE, goes to STOP if a stop was requested and to IDLE otherwise.
- STOP to IDLE.
- Any operation that reports lost arbitration goes straight to IDLE.

Top module: `i2cseq_top`

## Requirements
- R1: After reset the block is idle: `busy`, `op_req`, `bus_busy` and all three flags are 0, and `master_mode` follows `cfg_master`.
- R2: A command write is accepted only with `cmd_start`=1, `ctl_en`=1, master mode active and `byte_count` nonzero. A write with a zero count or with `ctl_en`=0 issues no operation and sets no flag.
- R3: Operation codes on `op_code` are 1 START, 2 repeated START, 3 STOP, 4 WRITE, 5 READ. A transfer begins with START, then a WRITE whose byte is the address in bits 7:1 and the inverse of `cmd_tx` in bit 0.
- R4: In transmit mode each of the counted bytes is popped from the TX FIFO, only while `tx_valid`=1. Each is then sent as a WRITE, in FIFO order.
- R5: In receive mode the block issues exactly `byte_count` READ operations. `op_ack_out`=0 (acknowledge) on every read but the last, and 1 on the last. Each read byte is pushed into the RX FIFO in the cycle its `op_done` arrives.
- R6: With a stop requested, a STOP follows the last byte. `flag_ardy` is set when the STOP completes.
- R7: Without a stop, `flag_ardy` is set after the last byte with no STOP, and the bus stays held. The next accepted start issues a repeated START without waiting for `bus_busy` to clear.
- R8: When the bus is not held and `bus_busy`=1, an accepted start waits and issues START only after `bus_busy` clears.
- R9: A NACK on the address byte or on a transmitted byte sets `flag_nack` and ends the data phase. No further byte is popped. STOP follows if it was requested, and `flag_ardy` is set.
- R10: After a transfer that ended without a stop, a write with `cmd_start`=0 and `cmd_stop`=1 issues a STOP and sets `flag_ardy`.
- R11: Lost arbitration sets `flag_al` and `flag_ardy`, issues no further operation, and drops `master_mode` and `bus_drive_en`. Commands are refused until `cfg_master` is taken low and high again.
- R12: `bus_busy` is set by a detected START and cleared by a detected STOP.
- R13: `flag_clr` bit 0 clears `flag_ardy`, bit 1 clears `flag_nack` and bit 2 clears `flag_al`.
- R14: A command write while `busy`=1 is ignored. The running transfer keeps its address and count, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_en | input | 1 | Block enable |
| cfg_master | input | 1 | Master mode request |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start request in the command |
| cmd_stop | input | 1 | Stop request in the command |
| cmd_tx | input | 1 | Direction: 1 transmit, 0 receive |
| slave_addr | input | 7 | Target address |
| byte_count | input | CNT_W | Number of data bytes |
| flag_clr | input | 3 | Flag clear: bit 0 ardy, 1 nack, 2 al |
| busy | output | 1 | Transfer in progress |
| master_mode | output | 1 | Master mode currently active |
| bus_busy | output | 1 | Bus busy as seen from START/STOP detection |
| flag_ardy | output | 1 | Transfer finished |
| flag_nack | output | 1 | No acknowledge received |
| flag_al | output | 1 | Arbitration lost |
| bus_drive_en | output | 1 | Bit engine may drive SCL/SDA |
| op_req | output | 1 | Operation request to the bit engine |
| op_code | output | 3 | Operation code |
| op_wdata | output | 8 | Byte to write |
| op_ack_out | output | 1 | Acknowledge bit to send after a read (1 = NACK) |
| op_done | input | 1 | Operation finished |
| op_nack_in | input | 1 | NACK seen on a write |
| op_al_in | input | 1 | Arbitration lost during the operation |
| op_rdata | input | 8 | Byte read |
| tx_valid | input | 1 | TX FIFO has a byte |
| tx_data | input | 8 | TX FIFO head byte |
| tx_pop | output | 1 | Pop TX FIFO |
| rx_room | input | 1 | RX FIFO has space |
| rx_push | output | 1 | Push into RX FIFO |
| rx_data | output | 8 | Byte pushed into RX FIFO |
| det_start | input | 1 | START detected on the bus |
| det_stop | input | 1 | STOP detected on the bus |

## Verification
Transfers are driven with several input patterns:
- A three-byte write with stop and a two-byte read with stop check the operation order, the address bit 0 and the acknowledge placement on the last read.
- A write without stop followed by a read tells a repeated START apart from a plain START.
- A start issued while another master holds the bus checks that the block waits for the bus to go free.
- NACKs on the address byte and on a middle data byte separate the stop and no-stop endings, along with the stop-only write that follows.
- An arbitration loss, a zero count, a disabled block and a command during a running transfer show that refused or interrupted commands leave no trace on the operation stream.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_BUS,
        S_START,
        S_ADDR,
        S_TX_FETCH,
        S_TX_BYTE,
        S_RX_ROOM,
        S_RX_BYTE,
        S_STOP
    } seq_state_e;

    localparam logic [2:0] OP_NONE   = 3'd0;
    localparam logic [2:0] OP_START  = 3'd1;
    localparam logic [2:0] OP_RSTART = 3'd2;
    localparam logic [2:0] OP_STOP   = 3'd3;
    localparam logic [2:0] OP_WRITE  = 3'd4;
    localparam logic [2:0] OP_READ   = 3'd5;

    localparam int FL_ARDY = 0;
    localparam int FL_NACK = 1;
    localparam int FL_AL   = 2;
    localparam int FL_N    = 3;

endpackage

// File: rtl/i2cseq_busmon.sv
module i2cseq_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic det_start,
    input  logic det_stop,
    output logic bb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bb <= 1'b0;
        end else if (!en) begin
            bb <= 1'b0;
        end else if (det_stop) begin
            bb <= 1'b0;
        end else if (det_start) begin
            bb <= 1'b1;
        end
    end

    // R12
    bb_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && det_start && !det_stop) |=> bb);

    // R12
    bb_off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_stop |=> !bb);

endmodule

// File: rtl/i2cseq_bytecnt.sv
module i2cseq_bytecnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

    // R5
    cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/i2cseq_flags.sv
module i2cseq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end

        // R13
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]);
    end

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             cfg_master,
    input  logic             cmd_wr,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_tx,
    input  logic [6:0]       slave_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [2:0]       flag_clr,
    output logic             busy,
    output logic             master_mode,
    output logic             bus_busy,
    output logic             flag_ardy,
    output logic             flag_nack,
    output logic             flag_al,
    output logic             bus_drive_en,
    output logic             op_req,
    output logic [2:0]       op_code,
    output logic [7:0]       op_wdata,
    output logic             op_ack_out,
    input  logic             op_done,
    input  logic             op_nack_in,
    input  logic             op_al_in,
    input  logic [7:0]       op_rdata,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    input  logic             rx_room,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    input  logic             det_start,
    input  logic             det_stop
);

    seq_state_e state_q, state_d;

    logic [6:0] addr_q;
    logic       tx_q;
    logic       stop_q;
    logic       rep_q;
    logic       held_q;
    logic       al_lock_q;
    logic [7:0] data_q;

    logic cmd_ok, go, stop_only, load_cnt;
    logic cnt_dec, cnt_last;
    logic end_xfer;
    logic ev_hold, ev_stop, ev_al, ev_nack;
    logic [FL_N-1:0] fl_set, fl_q;

    // ---------------- sub-blocks ----------------
    i2cseq_busmon u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .det_start (det_start),
        .det_stop  (det_stop),
        .bb        (bus_busy)
    );

    i2cseq_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cnt),
        .load_val (byte_count),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    i2cseq_flags #(.N(FL_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (flag_clr),
        .q     (fl_q)
    );

    assign flag_ardy = fl_q[FL_ARDY];
    assign flag_nack = fl_q[FL_NACK];
    assign flag_al   = fl_q[FL_AL];

    // ---------------- command decode ----------------
    assign master_mode  = cfg_master && !al_lock_q;
    assign bus_drive_en = ctl_en && master_mode;
    assign cmd_ok       = cmd_wr && ctl_en && master_mode;
    assign go           = cmd_ok && cmd_start && (byte_count != '0);
    assign stop_only    = cmd_ok && !cmd_start && cmd_stop && held_q;
    assign load_cnt     = (state_q == S_IDLE) && go;
    assign busy         = (state_q != S_IDLE);

    // ---------------- next state and events ----------------
    always_comb begin
        state_d  = state_q;
        end_xfer = 1'b0;
        cnt_dec  = 1'b0;
        ev_hold  = 1'b0;
        ev_stop  = 1'b0;
        ev_al    = 1'b0;
        ev_nack  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (go) begin
                    state_d = (held_q || !bus_busy) ? S_START : S_WAIT_BUS;
                end else if (stop_only) begin
                    state_d = S_STOP;
                end
            end
            S_WAIT_BUS: begin
                if (!bus_busy) state_d = S_START;
            end
            S_START: begin
                if (op_done) begin
                    if (op_al_in) begin
                        ev_al   = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_ADDR;
                    end
                end
            end
            S_ADDR: begin
                if (op_done) begin
                    if (op_al_in) begin
                        ev_al   = 1'b1;
                        state_d = S_IDLE;
                    end else if (op_nack_in) begin
                        ev_nack  = 1'b1;
                        end_xfer = 1'b1;
                    end else begin
                        state_d = tx_q ? S_TX_FETCH : S_RX_ROOM;
                    end
                end
            end
            S_TX_FETCH: begin
                if (tx_valid) state_d = S_TX_BYTE;
            end
            S_TX_BYTE: begin
                if (op_done) begin
                    if (op_al_in) begin
                        ev_al   = 1'b1;
                        state_d = S_IDLE;
                    end else if (op_nack_in) begin
                        ev_nack  = 1'b1;
                        end_xfer = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                        if (cnt_last) end_xfer = 1'b1;
                        else          state_d  = S_TX_FETCH;
                    end
                end
            end
            S_RX_ROOM: begin
                if (rx_room) state_d = S_RX_BYTE;
            end
            S_RX_BYTE: begin
                if (op_done) begin
                    if (op_al_in) begin
                        ev_al   = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        cnt_dec = 1'b1;
                        if (cnt_last) end_xfer = 1'b1;
                        else          state_d  = S_RX_ROOM;
                    end
                end
            end
            S_STOP: begin
                if (op_done) begin
                    if (op_al_in) ev_al   = 1'b1;
                    else          ev_stop = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (end_xfer) begin
            if (stop_q) begin
                state_d = S_STOP;
            end else begin
                state_d = S_IDLE;
                ev_hold = 1'b1;
            end
        end
    end

    always_comb begin
        fl_set          = '0;
        fl_set[FL_ARDY] = ctl_en && (ev_hold || ev_stop || ev_al);
        fl_set[FL_NACK] = ctl_en && ev_nack;
        fl_set[FL_AL]   = ctl_en && ev_al;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            tx_q    <= 1'b0;
            stop_q  <= 1'b0;
            rep_q   <= 1'b0;
            held_q  <= 1'b0;
            data_q  <= '0;
        end else if (!ctl_en) begin
            state_q <= S_IDLE;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_cnt) begin
                addr_q <= slave_addr;
                tx_q   <= cmd_tx;
                stop_q <= cmd_stop;
                rep_q  <= held_q;
            end
            if (state_q == S_TX_FETCH && tx_valid) begin
                data_q <= tx_data;
            end
            if (ev_hold) begin
                held_q <= 1'b1;
            end else if (ev_stop || ev_al) begin
                held_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_lock_q <= 1'b0;
        end else if (ev_al && ctl_en) begin
            al_lock_q <= 1'b1;
        end else if (!cfg_master) begin
            al_lock_q <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        op_req     = 1'b0;
        op_code    = OP_NONE;
        op_wdata   = '0;
        op_ack_out = 1'b0;
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        rx_data    = '0;
        unique case (state_q)
            S_START: begin
                op_req  = 1'b1;
                op_code = rep_q ? OP_RSTART : OP_START;
            end
            S_ADDR: begin
                op_req   = 1'b1;
                op_code  = OP_WRITE;
                op_wdata = {addr_q, ~tx_q};
            end
            S_TX_FETCH: begin
                tx_pop = tx_valid;
            end
            S_TX_BYTE: begin
                op_req   = 1'b1;
                op_code  = OP_WRITE;
                op_wdata = data_q;
            end
            S_RX_BYTE: begin
                op_req     = 1'b1;
                op_code    = OP_READ;
                op_ack_out = cnt_last;
                rx_push    = op_done && !op_al_in;
                rx_data    = op_rdata;
            end
            S_STOP: begin
                op_req  = 1'b1;
                op_code = OP_STOP;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    // R4
    tx_byte_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n || !ctl_en)
        tx_pop |=> (op_req && op_code == OP_WRITE && op_wdata == $past(tx_data)));

    // R6
    stop_ardy_chk: assert property (@(posedge clk) disable iff (!rst_n || !ctl_en)
        (op_req && op_done && op_code == OP_STOP && !op_al_in) |=> flag_ardy);

    // R11
    al_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !ctl_en)
        (op_req && op_done && op_al_in) |=> (!bus_drive_en && flag_al));

    // R5
    rx_last_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !ctl_en)
        (op_req && op_code == OP_READ && op_done && op_ack_out) |=> !(op_req && op_code == OP_READ));

endmodule

// File: tb/i2cseq_top_tb_top.sv
module i2cseq_top_tb_top;
    import i2cseq_pkg::*;

    localparam int CNT_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             ctl_en, cfg_master, cmd_wr, cmd_start, cmd_stop, cmd_tx;
    logic [6:0]       slave_addr;
    logic [CNT_W-1:0] byte_count;
    logic [2:0]       flag_clr;
    logic             busy, master_mode, bus_busy, flag_ardy, flag_nack, flag_al, bus_drive_en;
    logic             op_req, op_ack_out, op_done, op_nack_in, op_al_in;
    logic [2:0]       op_code;
    logic [7:0]       op_wdata, op_rdata;
    logic             tx_valid, tx_pop, rx_room, rx_push;
    logic [7:0]       tx_data, rx_data;
    logic             det_start, det_stop;
    logic             ext_start, ext_stop, m_start, m_stop;

    assign det_start = ext_start | m_start;
    assign det_stop  = ext_stop | m_stop;

    i2cseq_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .cfg_master(cfg_master),
        .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_tx(cmd_tx),
        .slave_addr(slave_addr), .byte_count(byte_count), .flag_clr(flag_clr),
        .busy(busy), .master_mode(master_mode), .bus_busy(bus_busy),
        .flag_ardy(flag_ardy), .flag_nack(flag_nack), .flag_al(flag_al),
        .bus_drive_en(bus_drive_en), .op_req(op_req), .op_code(op_code),
        .op_wdata(op_wdata), .op_ack_out(op_ack_out), .op_done(op_done),
        .op_nack_in(op_nack_in), .op_al_in(op_al_in), .op_rdata(op_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_room(rx_room), .rx_push(rx_push), .rx_data(rx_data),
        .det_start(det_start), .det_stop(det_stop)
    );

    int checks = 0;
    int errors = 0;

    // stimulus configuration, written only by the main sequence
    int         test_id = 0;
    int         nack_at = -1;
    int         al_at   = -1;
    int         tx_len  = 0;
    logic [7:0] tx_mem [0:7];
    logic [7:0] rd_src [0:7];

    // model state, written only by the bus model
    int         seen_id = 0;
    int         op_n, tx_idx, rd_idx, rx_n, cur, wait_c;
    bit         busy_r, pop_pend;
    logic [2:0] cur_code;
    logic [2:0] lg_code [0:31];
    logic [7:0] lg_data [0:31];
    logic       lg_ack  [0:31];
    logic [7:0] rx_log  [0:7];

    // bit engine, FIFO and bus detector model
    initial begin
        op_done = 0; op_nack_in = 0; op_al_in = 0; op_rdata = 0;
        m_start = 0; m_stop = 0; tx_valid = 0; tx_data = 0; rx_room = 1;
        op_n = 0; tx_idx = 0; rd_idx = 0; rx_n = 0; cur = 0; wait_c = 0;
        busy_r = 0; pop_pend = 0; cur_code = OP_NONE;
        forever begin
            @(negedge clk);
            if (seen_id != test_id) begin
                seen_id = test_id; op_n = 0; tx_idx = 0; rd_idx = 0; rx_n = 0; pop_pend = 0;
            end
            if (pop_pend) begin tx_idx++; pop_pend = 0; end
            tx_valid = (tx_idx < tx_len);
            tx_data  = tx_mem[tx_idx % 8];
            if (op_done) begin
                op_done = 0; op_nack_in = 0; op_al_in = 0; m_start = 0; m_stop = 0; busy_r = 0;
            end
            if (busy_r) begin
                wait_c--;
                if (wait_c == 0) begin
                    op_done    = 1;
                    op_nack_in = (cur == nack_at);
                    op_al_in   = (cur == al_at);
                    op_rdata   = rd_src[rd_idx % 8];
                    if (cur_code == OP_READ) rd_idx++;
                    if (cur_code == OP_START || cur_code == OP_RSTART) m_start = 1;
                    if (cur_code == OP_STOP) m_stop = 1;
                    #1;
                    if (rx_push) begin rx_log[rx_n % 8] = rx_data; rx_n++; end
                end
            end else if (op_req) begin
                cur = op_n; cur_code = op_code;
                if (op_n < 32) begin
                    lg_code[op_n] = op_code; lg_data[op_n] = op_wdata; lg_ack[op_n] = op_ack_out;
                end
                op_n++; busy_r = 1; wait_c = 2;
            end
            #1;
            if (tx_pop) pop_pend = 1;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic new_test();
        test_id++;
        nack_at = -1; al_at = -1; tx_len = 0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic issue(bit st, bit sp, bit tx, logic [6:0] a, int n);
        @(negedge clk);
        cmd_wr = 1; cmd_start = st; cmd_stop = sp; cmd_tx = tx;
        slave_addr = a; byte_count = CNT_W'(n);
        @(negedge clk);
        cmd_wr = 0; cmd_start = 0; cmd_stop = 0;
    endtask

    task automatic wait_ardy(string req);
        int n = 0;
        while (!flag_ardy && n < 400) begin @(negedge clk); n++; end
        chk(req, "ardy reached", int'(flag_ardy), 1);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 3'b111;
        @(negedge clk); flag_clr = 3'b000;
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "op_req", int'(op_req), 0);
        chk("R1", "bus_busy", int'(bus_busy), 0);
        chk("R1", "flags", int'({flag_ardy, flag_nack, flag_al}), 0);
        chk("R1", "master_mode", int'(master_mode), 1);
    endtask

    task automatic t_write_stop();
        new_test();
        tx_mem[0] = 8'h11; tx_mem[1] = 8'h22; tx_mem[2] = 8'h33; tx_len = 3;
        issue(1, 1, 1, 7'h50, 3);
        wait_ardy("R6");
        chk("R3", "op count", op_n, 6);
        chk("R3", "op0 code", int'(lg_code[0]), int'(OP_START));
        chk("R3", "addr byte", int'(lg_data[1]), 8'hA0);
        chk("R4", "d0", int'(lg_data[2]), 8'h11);
        chk("R4", "d1", int'(lg_data[3]), 8'h22);
        chk("R4", "d2", int'(lg_data[4]), 8'h33);
        chk("R4", "pops", tx_idx, 3);
        chk("R6", "op5 stop", int'(lg_code[5]), int'(OP_STOP));
        chk("R12", "bus free after stop", int'(bus_busy), 0);
        clear_flags();
    endtask

    task automatic t_read_stop();
        new_test();
        rd_src[0] = 8'h5A; rd_src[1] = 8'hC3;
        issue(1, 1, 0, 7'h1D, 2);
        wait_ardy("R5");
        chk("R3", "read addr byte", int'(lg_data[1]), 8'h3B);
        chk("R5", "op count", op_n, 5);
        chk("R5", "rd0 code", int'(lg_code[2]), int'(OP_READ));
        chk("R5", "rd0 ack", int'(lg_ack[2]), 0);
        chk("R5", "rd1 nack", int'(lg_ack[3]), 1);
        chk("R5", "pushes", rx_n, 2);
        chk("R5", "rx0", int'(rx_log[0]), 8'h5A);
        chk("R5", "rx1", int'(rx_log[1]), 8'hC3);
        clear_flags();
    endtask

    task automatic t_refused();
        new_test();
        issue(1, 1, 1, 7'h12, 0);
        repeat (10) @(negedge clk);
        chk("R2", "zero count ops", op_n, 0);
        chk("R2", "zero count ardy", int'(flag_ardy), 0);
        ctl_en = 0;
        tx_len = 1;
        issue(1, 1, 1, 7'h12, 1);
        repeat (10) @(negedge clk);
        chk("R2", "disabled ops", op_n, 0);
        ctl_en = 1;
        repeat (2) @(negedge clk);
        chk("R2", "disabled busy", int'(busy), 0);
    endtask

    task automatic t_rstart();
        new_test();
        tx_mem[0] = 8'h9C; tx_len = 1;
        issue(1, 0, 1, 7'h10, 1);
        wait_ardy("R7");
        chk("R7", "no stop op count", op_n, 3);
        chk("R7", "bus held", int'(bus_busy), 1);
        chk("R7", "idle", int'(busy), 0);
        clear_flags();
        chk("R13", "ardy cleared", int'(flag_ardy), 0);
        new_test();
        rd_src[0] = 8'h77;
        issue(1, 1, 0, 7'h10, 1);
        wait_ardy("R7");
        chk("R7", "repeated start", int'(lg_code[0]), int'(OP_RSTART));
        chk("R7", "addr byte", int'(lg_data[1]), 8'h21);
        chk("R5", "single read nack", int'(lg_ack[2]), 1);
        chk("R7", "op count", op_n, 4);
        clear_flags();
    endtask

    task automatic t_nack_addr();
        new_test();
        tx_mem[0] = 8'h01; tx_mem[1] = 8'h02; tx_len = 2; nack_at = 1;
        issue(1, 1, 1, 7'h44, 2);
        wait_ardy("R9");
        chk("R9", "nack flag", int'(flag_nack), 1);
        chk("R9", "op count", op_n, 3);
        chk("R9", "stop after nack", int'(lg_code[2]), int'(OP_STOP));
        chk("R9", "no pop", tx_idx, 0);
        clear_flags();
    endtask

    task automatic t_nack_data();
        new_test();
        tx_mem[0] = 8'hA1; tx_mem[1] = 8'hA2; tx_mem[2] = 8'hA3; tx_len = 3; nack_at = 3;
        issue(1, 0, 1, 7'h2A, 3);
        wait_ardy("R9");
        chk("R9", "data nack flag", int'(flag_nack), 1);
        chk("R9", "op count", op_n, 4);
        chk("R9", "pops", tx_idx, 2);
        chk("R10", "bus held", int'(bus_busy), 1);
        clear_flags();
        issue(0, 1, 0, 7'h2A, 0);
        wait_ardy("R10");
        chk("R10", "stop issued", int'(lg_code[4]), int'(OP_STOP));
        chk("R10", "op count", op_n, 5);
        chk("R10", "bus freed", int'(bus_busy), 0);
        clear_flags();
    endtask

    task automatic t_busy_wait();
        new_test();
        @(negedge clk); ext_start = 1;
        @(negedge clk); ext_start = 0;
        chk("R12", "bb set", int'(bus_busy), 1);
        tx_mem[0] = 8'h5F; tx_len = 1;
        issue(1, 1, 1, 7'h05, 1);
        repeat (10) @(negedge clk);
        chk("R8", "waiting ops", op_n, 0);
        chk("R8", "waiting busy", int'(busy), 1);
        @(negedge clk); ext_stop = 1;
        @(negedge clk); ext_stop = 0;
        chk("R12", "bb cleared", int'(bus_busy), 0);
        wait_ardy("R8");
        chk("R8", "plain start", int'(lg_code[0]), int'(OP_START));
        chk("R8", "op count", op_n, 4);
        clear_flags();
    endtask

    task automatic t_ignore();
        new_test();
        tx_mem[0] = 8'h10; tx_mem[1] = 8'h20; tx_len = 2;
        issue(1, 1, 1, 7'h22, 2);
        repeat (3) @(negedge clk);
        issue(1, 1, 1, 7'h33, 1);
        wait_ardy("R14");
        chk("R14", "addr kept", int'(lg_data[1]), 8'h44);
        chk("R14", "count kept", op_n, 5);
        clear_flags();
        repeat (12) @(negedge clk);
        chk("R14", "no second xfer", int'(flag_ardy), 0);
        chk("R14", "no extra ops", op_n, 5);
    endtask

    task automatic t_arb_lost();
        new_test();
        tx_mem[0] = 8'hEE; tx_len = 1; al_at = 1;
        issue(1, 1, 1, 7'h60, 1);
        wait_ardy("R11");
        chk("R11", "al flag", int'(flag_al), 1);
        chk("R11", "master dropped", int'(master_mode), 0);
        chk("R11", "drive released", int'(bus_drive_en), 0);
        chk("R11", "op count", op_n, 2);
        issue(1, 1, 1, 7'h60, 1);
        repeat (10) @(negedge clk);
        chk("R11", "refused ops", op_n, 2);
        chk("R11", "refused busy", int'(busy), 0);
        cfg_master = 0; @(negedge clk);
        cfg_master = 1; @(negedge clk);
        chk("R11", "master back", int'(master_mode), 1);
        @(negedge clk); ext_stop = 1;
        @(negedge clk); ext_stop = 0;
        clear_flags();
        chk("R13", "all flags cleared", int'({flag_ardy, flag_nack, flag_al}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; ctl_en = 1; cfg_master = 1; cmd_wr = 0; cmd_start = 0; cmd_stop = 0;
        cmd_tx = 0; slave_addr = 0; byte_count = 0; flag_clr = 0; ext_start = 0; ext_stop = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_stop();
        t_read_stop();
        t_refused();
        t_rstart();
        t_nack_addr();
        t_nack_data();
        t_busy_wait();
        t_ignore();
        t_arb_lost();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule